// File: doc/BRIEF.md
# Bus Controller Frame Sequencer

This block walks a bus controller through a frame: an ordered list of message-descriptor words held in RAM. The host writes a list address and a message count into one of two start/count register pairs. It picks a pair and an error policy in a configuration register, then pulses `go`. For each list entry the sequencer reads one word from RAM. It hands that word to an external message engine with a one-cycle `msg_start` pulse and waits for `msg_done`.

When the engine flags `msg_err`, the sequencer applies one of seven programmable reactions. It can let the message finish, drop to the next entry, skip to the end of the frame, stop after the message, stop after the frame, go off line, or switch to the default frame (register pair 1). An optional loop mode restarts the frame after each end-of-frame. A one-cycle `eof` pulse marks each completed frame. `offline` stays set until the next accepted `go`.

Top module: `bc_frame_seq`

## Requirements
- R1: After reset, `busy`, `eof`, `offline`, `msg_start`, `msg_abort` and `ram_rd` are all 0.
- R2: A `go` pulse while `busy` is 0 starts a run and clears `offline`. The run uses pair 0 (selector 0 start, selector 1 count) or pair 1 (selector 2 start, selector 3 count), as config bit 3 chooses. The count field is 10 bits and holds the message count minus one, so 1 to 1024 messages. A `go` while `busy` is 1 is ignored.
- R3: Entry i of a frame is read from RAM address start+i with a one-cycle `ram_rd`. The word returned on the cycle after `ram_rd` is presented on `msg_desc` two cycles after `ram_rd`, together with a one-cycle `msg_start`.
- R4: After the programmed number of messages complete, the frame ends: `eof` pulses for one cycle and `busy` falls, unless loop mode restarts the frame.
- R5: Register selector 4 is the configuration word: bits [2:0] are the error action, bit 3 is the pair select and bit 4 is loop mode. Errors are acted on only while a message is outstanding.
- R6: Action 0: an error lets the message run to `msg_done`, then sequencing continues normally.
- R7: Actions 1 and 7: an error moves at once to the next entry. If `msg_done` is not also high, `msg_abort` is raised in that same cycle.
- R8: Action 2: an error ends the frame at once (`eof` pulse, `msg_abort` if the message is unfinished). No further entries of that frame are started.
- R9: Action 3: after an errored message completes, the sequencer stops without `eof`. Action 4: the current frame is completed and the sequencer then stops, even in loop mode.
- R10: Action 5: an error ends the run at once with `msg_abort` and sets `offline`. `offline` stays 1 until the next accepted `go`.
- R11: Action 6: an error abandons the current frame and starts pair 1 (the default frame) from its first entry.
- R12: In loop mode, after `eof` the active pair's frame restarts from its first entry without a new `go`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register selector (0..4) |
| reg_wdata | input | AW | Register write data |
| go | input | 1 | Start command |
| ram_rd | output | 1 | RAM read strobe |
| ram_addr | output | AW | RAM read address |
| ram_rdata | input | DW | RAM read data, valid the cycle after `ram_rd` |
| msg_start | output | 1 | Start pulse to the message engine |
| msg_desc | output | DW | Descriptor word for the message engine |
| msg_done | input | 1 | Message engine finished |
| msg_err | input | 1 | Message engine error flag |
| msg_abort | output | 1 | Current message is abandoned |
| busy | output | 1 | A run is in progress |
| eof | output | 1 | One-cycle end-of-frame pulse |
| offline | output | 1 | Controller taken off line by an abort |

## Verification
A corrupted list pointer or count shows up as a wrong descriptor on the next `msg_start`, three cycles after the faulty state is loaded, or as a wrong number of starts before `busy` falls. A mis-decoded error action appears within one cycle of `msg_err`, as a missing or extra `msg_abort`. It also appears later as a changed start count, a missing `eof` or a wrong `offline` level once the run ends. Each run therefore records every started descriptor and counts `eof` and abort pulses, and compares the totals with the value each error policy implies.

// File: rtl/bc_frame_seq.sv
module bc_frame_seq #(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int LW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [2:0]    reg_sel,
  input  logic [AW-1:0] reg_wdata,
  input  logic          go,
  output logic          ram_rd,
  output logic [AW-1:0] ram_addr,
  input  logic [DW-1:0] ram_rdata,
  output logic          msg_start,
  output logic [DW-1:0] msg_desc,
  input  logic          msg_done,
  input  logic          msg_err,
  output logic          msg_abort,
  output logic          busy,
  output logic          eof,
  output logic          offline
);
  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_LATCH, S_ISSUE, S_WAIT} st_t;
  st_t st;

  logic [AW-1:0] start0, start1, ptr;
  logic [LW-1:0] cnt0, cnt1, len, cnt;
  logic [2:0]    act;
  logic          psel, loop, cur, stop_pend, err_seen;
  logic [DW-1:0] desc;

  wire in_wait  = (st == S_WAIT);
  wire immed    = (act == 3'd1) || (act == 3'd2) || (act == 3'd5) ||
                  (act == 3'd6) || (act == 3'd7);
  wire err_hit  = msg_err || err_seen;
  wire take_imm = in_wait && msg_err && immed;
  wire take_end = in_wait && msg_done && !take_imm;
  wire stop_msg = take_end && err_hit && (act == 3'd3);
  wire adv      = (take_imm && (act == 3'd1 || act == 3'd7)) || (take_end && !stop_msg);
  wire last     = (cnt == len);
  wire endf     = (adv && last) || (take_imm && act == 3'd2);
  wire stop_nx  = stop_pend || (take_end && err_hit && act == 3'd4);

  assign ram_rd    = (st == S_FETCH);
  assign ram_addr  = ptr;
  assign msg_start = (st == S_ISSUE);
  assign msg_desc  = desc;
  assign msg_abort = take_imm && !msg_done;
  assign busy      = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start0 <= '0;
      start1 <= '0;
      cnt0   <= '0;
      cnt1   <= '0;
      act    <= '0;
      psel   <= 1'b0;
      loop   <= 1'b0;
    end else if (reg_we) begin
      case (reg_sel)
        3'd0: start0 <= reg_wdata;
        3'd1: cnt0   <= reg_wdata[LW-1:0];
        3'd2: start1 <= reg_wdata;
        3'd3: cnt1   <= reg_wdata[LW-1:0];
        3'd4: begin
          act  <= reg_wdata[2:0];
          psel <= reg_wdata[3];
          loop <= reg_wdata[4];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      ptr       <= '0;
      len       <= '0;
      cnt       <= '0;
      cur       <= 1'b0;
      stop_pend <= 1'b0;
      err_seen  <= 1'b0;
      desc      <= '0;
      eof       <= 1'b0;
      offline   <= 1'b0;
    end else begin
      eof <= 1'b0;
      case (st)
        S_IDLE: if (go) begin
          cur       <= psel;
          ptr       <= psel ? start1 : start0;
          len       <= psel ? cnt1 : cnt0;
          cnt       <= '0;
          stop_pend <= 1'b0;
          offline   <= 1'b0;
          st        <= S_FETCH;
        end
        S_FETCH: st <= S_LATCH;
        S_LATCH: begin
          desc <= ram_rdata;
          st   <= S_ISSUE;
        end
        S_ISSUE: begin
          err_seen <= 1'b0;
          st       <= S_WAIT;
        end
        S_WAIT: begin
          stop_pend <= stop_nx;
          if (msg_err && !immed) err_seen <= 1'b1;
          if (endf) begin
            eof <= 1'b1;
            if (loop && !stop_nx) begin
              ptr <= cur ? start1 : start0;
              len <= cur ? cnt1 : cnt0;
              cnt <= '0;
              st  <= S_FETCH;
            end else begin
              st <= S_IDLE;
            end
          end else if (adv) begin
            ptr <= ptr + 1'b1;
            cnt <= cnt + 1'b1;
            st  <= S_FETCH;
          end else if (take_imm && act == 3'd5) begin
            offline <= 1'b1;
            st      <= S_IDLE;
          end else if (take_imm && act == 3'd6) begin
            cur <= 1'b1;
            ptr <= start1;
            len <= cnt1;
            cnt <= '0;
            st  <= S_FETCH;
          end else if (stop_msg) begin
            st <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module bc_frame_seq_chk #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          go,
  input logic          ram_rd,
  input logic          msg_start,
  input logic          msg_done,
  input logic          msg_err,
  input logic          msg_abort,
  input logic          busy,
  input logic          eof,
  input logic          offline
);
  // R3
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_start |=> !msg_start);
  // R3
  read_to_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_rd |=> ##1 msg_start);
  // R4
  eof_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eof |=> !eof);
  // R10
  offline_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (offline && !go) |=> offline);
  // R7
  abort_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_abort |-> (msg_err && !msg_done && busy));
  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !go) |=> !busy);
  // R3
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_start |-> busy);
endmodule

bind bc_frame_seq bc_frame_seq_chk #(.AW(AW), .DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .go(go), .ram_rd(ram_rd), .msg_start(msg_start),
  .msg_done(msg_done), .msg_err(msg_err), .msg_abort(msg_abort),
  .busy(busy), .eof(eof), .offline(offline)
);

// File: tb/bc_frame_seq_tb.sv
module bc_frame_seq_tb_top;
  localparam int AW = 16;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_we = 1'b0;
  logic [2:0]    reg_sel = '0;
  logic [AW-1:0] reg_wdata = '0;
  logic          go = 1'b0;
  logic          ram_rd;
  logic [AW-1:0] ram_addr;
  logic [DW-1:0] ram_rdata = '0;
  logic          msg_start;
  logic [DW-1:0] msg_desc;
  logic          msg_done = 1'b0;
  logic          msg_err = 1'b0;
  logic          msg_abort, busy, eof, offline;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  always @(posedge clk) if (ram_rd) ram_rdata <= ram_addr ^ 16'h5A00;

  bc_frame_seq dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .go(go), .ram_rd(ram_rd), .ram_addr(ram_addr),
    .ram_rdata(ram_rdata), .msg_start(msg_start), .msg_desc(msg_desc),
    .msg_done(msg_done), .msg_err(msg_err), .msg_abort(msg_abort),
    .busy(busy), .eof(eof), .offline(offline)
  );

  typedef struct packed {
    logic [2:0]  act;
    logic        loop;
    logic        sel;
    logic [9:0]  lenf;
    logic [3:0]  errm;
    logic        early;
    logic [11:0] nst;
    logic [15:0] first;
    logic [15:0] last;
    logic [3:0]  neof;
    logic [3:0]  nab;
    logic        off;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{3'd0,1'b0,1'b0,10'd3,   4'd15,1'b0,12'd4,   16'h0100,16'h0103,4'd1,4'd0,1'b0,4'd4},  // R4
    '{3'd0,1'b0,1'b0,10'd3,   4'd1, 1'b1,12'd4,   16'h0100,16'h0103,4'd1,4'd0,1'b0,4'd6},  // R6
    '{3'd1,1'b0,1'b0,10'd3,   4'd1, 1'b1,12'd4,   16'h0100,16'h0103,4'd1,4'd1,1'b0,4'd7},  // R7
    '{3'd2,1'b0,1'b0,10'd3,   4'd1, 1'b1,12'd2,   16'h0100,16'h0101,4'd1,4'd1,1'b0,4'd8},  // R8
    '{3'd3,1'b0,1'b0,10'd3,   4'd1, 1'b0,12'd2,   16'h0100,16'h0101,4'd0,4'd0,1'b0,4'd9},  // R9
    '{3'd4,1'b1,1'b0,10'd3,   4'd1, 1'b0,12'd4,   16'h0100,16'h0103,4'd1,4'd0,1'b0,4'd9},  // R9
    '{3'd5,1'b0,1'b0,10'd3,   4'd2, 1'b1,12'd3,   16'h0100,16'h0102,4'd0,4'd1,1'b1,4'd10}, // R10
    '{3'd6,1'b0,1'b0,10'd3,   4'd1, 1'b1,12'd4,   16'h0100,16'h0201,4'd1,4'd1,1'b0,4'd11}, // R11 (offline cleared: R10)
    '{3'd7,1'b0,1'b0,10'd3,   4'd0, 1'b0,12'd4,   16'h0100,16'h0103,4'd1,4'd0,1'b0,4'd7},  // R7
    '{3'd0,1'b0,1'b1,10'd3,   4'd15,1'b0,12'd2,   16'h0200,16'h0201,4'd1,4'd0,1'b0,4'd2},  // R2, R5
    '{3'd0,1'b0,1'b0,10'd0,   4'd15,1'b0,12'd1,   16'h0100,16'h0100,4'd1,4'd0,1'b0,4'd2},  // R2
    '{3'd0,1'b0,1'b0,10'd1023,4'd15,1'b0,12'd1024,16'h0100,16'h04FF,4'd1,4'd0,1'b0,4'd2},  // R2
    '{3'd4,1'b1,1'b0,10'd3,   4'd5, 1'b0,12'd8,   16'h0100,16'h0103,4'd2,4'd0,1'b0,4'd12}, // R12
    '{3'd1,1'b0,1'b0,10'd3,   4'd1, 1'b0,12'd4,   16'h0100,16'h0103,4'd1,4'd0,1'b0,4'd7}   // R7
  };

  task automatic chk(input logic [31:0] act_v, input logic [31:0] exp_v,
                     input int req, input string what);
    checks++;
    if (act_v !== exp_v) begin
      errors++;
      $display("FAIL R%0d %s actual=%0h expected=%0h", req, what, act_v, exp_v);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic run(input vec_t v, input bit xgo);
    int nst = 0, neof = 0, nab = 0, phase = 0, idx = 0;
    logic [15:0] first = '0, last = '0;
    wr(3'd0, 16'h0100);
    wr(3'd1, {6'd0, v.lenf});
    wr(3'd2, 16'h0200);
    wr(3'd3, 16'd1);
    wr(3'd4, {11'd0, v.loop, v.sel, v.act});
    @(negedge clk); go = 1'b1;
    @(negedge clk); go = 1'b0;
    for (int cyc = 0; cyc < 8000; cyc++) begin
      if (xgo) go = (cyc == 6);
      case (phase)
        1: if (idx == int'(v.errm) && v.early) begin
             msg_err = 1'b1; #1;
             if (msg_abort) begin nab++; phase = 4; end
             else phase = 2;
           end else begin
             msg_done = 1'b1;
             msg_err = (idx == int'(v.errm));
             #1;
             if (msg_abort) nab++;
             phase = 3;
           end
        2: begin msg_err = 1'b0; msg_done = 1'b1; phase = 3; end
        3: begin msg_err = 1'b0; msg_done = 1'b0; phase = 0; end
        4: begin msg_err = 1'b0; phase = 0; end
        default: ;
      endcase
      if (msg_start) begin
        if (nst == 0) first = msg_desc ^ 16'h5A00;
        last = msg_desc ^ 16'h5A00;
        idx = nst; nst++; phase = 1;
      end
      if (eof) neof++;
      if (!busy && phase == 0) break;
      @(negedge clk);
    end
    go = 1'b0;
    chk(nst, v.nst, v.req, "message starts");
    chk(first, v.first, v.req, "first entry address");
    chk(last, v.last, v.req, "last entry address");
    chk(neof, v.neof, v.req, "eof pulses");
    chk(nab, v.nab, v.req, "abort pulses");
    chk(offline, v.off, v.req, "offline");
    chk(busy, 1'b0, v.req, "busy at end");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(busy, 1'b0, 1, "busy in reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy, 1'b0, 1, "busy after reset");
    chk(eof, 1'b0, 1, "eof after reset");
    chk(offline, 1'b0, 1, "offline after reset");
    chk(msg_start, 1'b0, 1, "msg_start after reset");
    chk(ram_rd, 1'b0, 1, "ram_rd after reset");
    chk(msg_abort, 1'b0, 1, "msg_abort after reset");

    for (int i = 0; i < NV; i++) run(VEC[i], 1'b0);

    // R2: go while busy is ignored (same totals as a plain 4-message run)
    run(VEC[0], 1'b1);

    // R5: error outside an outstanding message is ignored
    msg_err = 1'b1;
    repeat (3) @(negedge clk);
    chk(busy, 1'b0, 5, "busy after idle error");
    chk(offline, 1'b0, 5, "offline after idle error");
    msg_err = 1'b0;

    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule